// File: doc/BRIEF.md
# Packed SIMD Saturating Rounding Shifter

This block shifts every element of a 128-bit packed data vector by its own signed amount. The amount for each lane comes from the matching element of a second 128-bit vector. A size input sets the element width to 8, 16, 32 or 64 bits, which gives 16, 8, 4 or 2 lanes. A mode input says whether the data elements are signed or unsigned. All lanes work in parallel.

A count of zero or more shifts the element left and clamps the result to the element range. A negative count shifts the element right by its magnitude. Before that shift, half of the last discarded weight is added, so the result rounds to nearest.

The block registers the packed result one cycle after an accepted operation and marks it with `valid_out`. It also keeps a sticky flag. The flag records that some lane of some accepted operation was clamped, and it stays set until software clears it.

Top module: `simd_qrshift`

## Requirements
- R1: The shift count of a lane is the low 8 bits of its shift element, read as a two's-complement value from -128 to 127. All higher bits of that element have no effect on the result.
- R2: When the count c is 0 or more, the lane result is the data element multiplied by 2^c, provided the product fits the element range.
- R3: When the count is -n, the lane result is (x + 2^(n-1)) >> n, computed at full precision. The shift is arithmetic in signed mode (`is_signed`=1) and logical in unsigned mode.
- R4: In unsigned mode, a result above 2^esize-1 is clamped to 2^esize-1 (all ones) and flags saturation.
- R5: In signed mode, a result outside -2^(esize-1) to 2^(esize-1)-1 is clamped to the nearer bound and flags saturation.
- R6: A left shift of a nonzero element by a count of esize or more, up to 127, always saturates and never wraps.
- R7: A right shift by a magnitude greater than esize, up to 128, gives 0 for every element, negative ones included. A right shift by exactly esize rounds using the element's top bit.
- R8: `size` selects the element width: 2'b00 = 8, 2'b01 = 16, 2'b10 = 32, 2'b11 = 64 bits. Each lane occupies bits [i*esize +: esize] and is computed independently of the others.
- R9: If any lane of an accepted operation saturates, `sat_sticky` is 1 from the next cycle on. Operations without saturation never clear it.
- R10: `sat_clr` clears `sat_sticky` on the next cycle, unless a saturating operation is accepted in the same cycle, in which case the flag stays 1.
- R11: `result` is updated one cycle after `valid_in`=1, and `valid_out` is `valid_in` delayed by one cycle. While `valid_in` is 0, `result` holds its value.
- R12: During reset and right after it, `valid_out`, `result` and `sat_sticky` are 0. Reset asserts asynchronously and is released on the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| valid_in | input | 1 | Accept an operation this cycle |
| size | input | 2 | Element width select (00=8, 01=16, 10=32, 11=64) |
| is_signed | input | 1 | 1: signed data and result elements; 0: unsigned |
| data_in | input | 128 | Packed data elements |
| shamt_in | input | 128 | Packed signed shift elements; the low byte of each is the count |
| sat_clr | input | 1 | Clear the sticky saturation flag |
| valid_out | output | 1 | `result` holds a new operation's outcome |
| result | output | 128 | Packed shifted and clamped elements |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
The assertions check the cycle-level control behaviour on every clock:
- `valid_out` follows `valid_in` one cycle later.
- `result` is held while no operation is accepted.
- The sticky flag is set, held and cleared exactly as the saturation and clear inputs require.

The arithmetic of each lane cannot be seen from those properties. That covers the rounding increment, the clamp bounds for each mode and width, the reading of only the low byte of the count, and the extreme counts 127, -128 and ±esize. Only the bench's scenarios can show these. They are compared against a behavioural model that shifts one doubling at a time and stops as soon as the value leaves the range.

// File: rtl/simd_qrshift_pkg.sv
package simd_qrshift_pkg;
  localparam int VEC_W = 128;
  localparam int CNT_W = 8;
  localparam int N_SIZES = 4;

  typedef enum logic [1:0] {
    ESZ_8  = 2'b00,
    ESZ_16 = 2'b01,
    ESZ_32 = 2'b10,
    ESZ_64 = 2'b11
  } esize_e;
endpackage

// File: rtl/qrs_rst_sync.sv
module qrs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/qrs_lane.sv
module qrs_lane #(
  parameter int W  = 8,
  parameter int CW = 8
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] cnt,
  input  logic          is_signed,
  output logic [W-1:0]  dout,
  output logic          sat
);
  // Width large enough that a left shift by the largest count never loses bits
  localparam int XW = W + (1 << (CW-1)) + 2;
  localparam int MW = CW + 1;

  logic                 neg;
  logic [MW-1:0]        mag;
  logic signed [XW-1:0] ext, inc, shl, rnd, val;
  logic                 fits_s, fits_u;

  always_comb begin
    neg = cnt[CW-1];
    mag = neg ? (MW'(0) - {cnt[CW-1], cnt}) : {1'b0, cnt};
    ext = {{(XW-W){is_signed & din[W-1]}}, din};
    inc = {{(XW-1){1'b0}}, 1'b1} << (mag - MW'(1));
    shl = ext <<< mag;
    rnd = (ext + inc) >>> mag;
    val = neg ? rnd : shl;
  end

  always_comb begin
    fits_s = (&val[XW-1:W-1]) | ~(|val[XW-1:W-1]);
    fits_u = ~(|val[XW-1:W]);
    sat    = is_signed ? ~fits_s : ~fits_u;
    if (!sat)           dout = val[W-1:0];
    else if (is_signed) dout = val[XW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else                dout = val[XW-1] ? {W{1'b0}} : {W{1'b1}};
  end
endmodule

// File: rtl/qrs_vector.sv
module qrs_vector
  import simd_qrshift_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter int CW = CNT_W
) (
  input  logic [VW-1:0] data,
  input  logic [VW-1:0] shamt,
  input  esize_e        size,
  input  logic          is_signed,
  output logic [VW-1:0] res,
  output logic          any_sat
);
  logic [N_SIZES-1:0][VW-1:0] res_by;
  logic [N_SIZES-1:0]         sat_by;

  for (genvar k = 0; k < N_SIZES; k++) begin : g_size
    localparam int W = 8 << k;
    localparam int N = VW / W;
    logic [N-1:0] lsat;
    for (genvar i = 0; i < N; i++) begin : g_lane
      qrs_lane #(.W(W), .CW(CW)) u_lane (
        .din      (data[i*W +: W]),
        .cnt      (shamt[i*W +: CW]),
        .is_signed(is_signed),
        .dout     (res_by[k][i*W +: W]),
        .sat      (lsat[i])
      );
    end
    assign sat_by[k] = |lsat;
  end

  always_comb begin
    res     = res_by[size];
    any_sat = sat_by[size];
  end
endmodule

// File: rtl/simd_qrshift.sv
module simd_qrshift
  import simd_qrshift_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_in,
  input  logic [1:0]   size,
  input  logic         is_signed,
  input  logic [127:0] data_in,
  input  logic [127:0] shamt_in,
  input  logic         sat_clr,
  output logic         valid_out,
  output logic [127:0] result,
  output logic         sat_sticky
);
  logic               rst_core_n;
  logic [VEC_W-1:0]   vec_res;
  logic               lane_sat_any;
  logic               valid_d, sticky_d;

  qrs_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_core_n(rst_core_n)
  );

  qrs_vector #(.VW(VEC_W), .CW(CNT_W)) u_vec (
    .data     (data_in),
    .shamt    (shamt_in),
    .size     (esize_e'(size)),
    .is_signed(is_signed),
    .res      (vec_res),
    .any_sat  (lane_sat_any)
  );

  always_comb begin
    valid_d  = valid_in;
    sticky_d = (sat_clr ? 1'b0 : sat_sticky) | (valid_in & lane_sat_any);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_out  <= 1'b0;
      sat_sticky <= 1'b0;
    end else begin
      valid_out  <= valid_d;
      sat_sticky <= sticky_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)   result <= '0;
    else if (valid_in) result <= vec_res;
  end
endmodule

// File: rtl/qrs_checker.sv
module qrs_checker (
  input logic         clk,
  input logic         rst_core_n,
  input logic         valid_in,
  input logic         sat_clr,
  input logic         lane_sat_any,
  input logic         valid_out,
  input logic [127:0] result,
  input logic         sat_sticky
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_core_n)
    valid_in |=> valid_out); // R11
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_core_n)
    !valid_in |=> !valid_out); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    !valid_in |=> $stable(result)); // R11
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_core_n)
    (valid_in && lane_sat_any) |=> sat_sticky); // R9
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sat_sticky && !sat_clr) |=> sat_sticky); // R9
  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sat_clr && !(valid_in && lane_sat_any)) |=> !sat_sticky); // R10
endmodule

bind simd_qrshift qrs_checker u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .valid_in    (valid_in),
  .sat_clr     (sat_clr),
  .lane_sat_any(lane_sat_any),
  .valid_out   (valid_out),
  .result      (result),
  .sat_sticky  (sat_sticky)
);

// File: tb/tb_simd_qrshift.sv
module tb_simd_qrshift;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         valid_in;
  logic [1:0]   size;
  logic         is_signed;
  logic [127:0] data_in, shamt_in;
  logic         sat_clr;
  logic         valid_out;
  logic [127:0] result;
  logic         sat_sticky;

  int compared = 0;
  int mismatched = 0;

  logic         exp_valid;
  logic [127:0] exp_result;
  logic         exp_sticky;
  string        exp_tag;

  always #10 clk = ~clk;

  simd_qrshift dut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .size(size),
    .is_signed(is_signed), .data_in(data_in), .shamt_in(shamt_in),
    .sat_clr(sat_clr), .valid_out(valid_out), .result(result),
    .sat_sticky(sat_sticky)
  );

  // Behavioural lane model: doubling loop for left shifts, wide arithmetic for right shifts
  task automatic lane_ref(input logic [63:0] d, input logic [7:0] s, input int w,
                          input bit sg, output logic [63:0] r, output bit sat);
    logic signed [199:0] x, lo, hi, one;
    int c;
    one = 200'sd1;
    x = '0;
    for (int b = 0; b < w; b++) x[b] = d[b];
    if (sg && d[w-1]) x = x - (one <<< w);
    if (sg) begin
      hi = (one <<< (w-1)) - one;
      lo = -(one <<< (w-1));
    end else begin
      hi = (one <<< w) - one;
      lo = '0;
    end
    c = int'($signed(s));
    if (c >= 0) begin
      for (int k = 0; k < c; k++) begin
        if (x > hi || x < lo) break;
        x = x * 2;
      end
    end else begin
      if (-c > w + 1) x = '0;
      else x = (x + (one <<< (-c - 1))) >>> (-c);
    end
    sat = 1'b0;
    if (x > hi) begin x = hi; sat = 1'b1; end
    if (x < lo) begin x = lo; sat = 1'b1; end
    r = '0;
    for (int b = 0; b < w; b++) r[b] = x[b];
  endtask

  task automatic vec_ref(input logic [127:0] d, input logic [127:0] s, input logic [1:0] sz,
                         input bit sg, output logic [127:0] r, output bit any);
    int w;
    logic [63:0] lr;
    bit ls;
    w = 8 << sz;
    r = '0;
    any = 1'b0;
    for (int i = 0; i < 128 / w; i++) begin
      lane_ref(64'(d >> (i*w)), s[i*w +: 8], w, sg, lr, ls);
      for (int b = 0; b < w; b++) r[i*w + b] = lr[b];
      any = any | ls;
    end
  endtask

  task automatic check_now();
    compared++;
    if (valid_out !== exp_valid) begin
      mismatched++;
      $display("FAIL %s valid_out: actual %b expected %b", exp_tag, valid_out, exp_valid);
    end
    compared++;
    if (result !== exp_result) begin
      mismatched++;
      $display("FAIL %s result: actual %h expected %h", exp_tag, result, exp_result);
    end
    compared++;
    if (sat_sticky !== exp_sticky) begin
      mismatched++;
      $display("FAIL %s sat_sticky: actual %b expected %b", exp_tag, sat_sticky, exp_sticky);
    end
  endtask

  // One clock: check the outputs of the last edge, then drive the next inputs and advance the model
  task automatic apply(input bit v, input logic [1:0] sz, input bit sg, input logic [127:0] d,
                       input logic [127:0] s, input bit clr, input string tag);
    logic [127:0] r;
    bit any;
    @(negedge clk);
    check_now();
    valid_in = v; size = sz; is_signed = sg; data_in = d; shamt_in = s; sat_clr = clr;
    vec_ref(d, s, sz, sg, r, any);
    exp_valid = v;
    if (v) exp_result = r;
    exp_sticky = (clr ? 1'b0 : exp_sticky) | (v & any);
    exp_tag = tag;
  endtask

  function automatic logic [127:0] put(input logic [127:0] v, input logic [1:0] sz,
                                       input int i, input logic [63:0] x);
    int w;
    logic [127:0] r;
    w = 8 << sz;
    r = v;
    for (int b = 0; b < w; b++) r[i*w + b] = x[b];
    return r;
  endfunction

  function automatic logic [127:0] splat(input logic [1:0] sz, input logic [63:0] x);
    logic [127:0] r;
    r = '0;
    for (int i = 0; i < (128 >> (3 + sz)); i++) r = put(r, sz, i, x);
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [127:0] small_counts(input logic [1:0] sz, input logic [127:0] base);
    int w;
    logic [127:0] r;
    w = 8 << sz;
    r = base;
    for (int i = 0; i < 128 / w; i++)
      r = put(r, sz, i, {base[i*w +: 56], 8'($signed(int'($urandom_range(0, 2*w + 8)) - (w + 4)))});
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [127:0] d, s;
    rst_n = 1'b0;
    valid_in = 1'b0; size = 2'b00; is_signed = 1'b0;
    data_in = '0; shamt_in = '0; sat_clr = 1'b0;
    exp_valid = 1'b0; exp_result = '0; exp_sticky = 1'b0; exp_tag = "R12";

    // R12: outputs are zero during reset and while the release propagates
    repeat (3) apply(0, 2'b00, 0, '0, '0, 0, "R12");
    rst_n = 1'b1;
    repeat (4) apply(0, 2'b00, 0, '0, '0, 0, "R12");

    // R2: small left shifts in 8-bit unsigned lanes
    d = '0; s = '0;
    for (int i = 0; i < 16; i++) begin
      d = put(d, 2'b00, i, 64'(i + 1));
      s = put(s, 2'b00, i, 64'(i % 4));
    end
    apply(1, 2'b00, 0, d, s, 0, "R2");

    // R1: high bits of 16-bit shift elements are garbage; low byte 0x02 means +2
    apply(1, 2'b01, 0, splat(2'b01, 64'h0011), splat(2'b01, 64'hAB02), 0, "R1");
    // R1: low byte 0xFF means -1, even with upper bits set
    apply(1, 2'b01, 1, splat(2'b01, 64'h0007), splat(2'b01, 64'h7FFF), 0, "R1");

    // R3: rounding right shifts, signed and unsigned
    d = put(put(put(put(splat(2'b00, 0), 2'b00, 0, 8'd7), 2'b00, 1, 8'hF9), 2'b00, 2, 8'hFB), 2'b00, 3, 8'd6);
    apply(1, 2'b00, 1, d, splat(2'b00, 64'hFF), 0, "R3");
    apply(1, 2'b00, 0, d, splat(2'b00, 64'hFE), 0, "R3");

    // R10: clear the flag (nothing set yet) then R4 unsigned clamp
    apply(0, 2'b00, 0, '0, '0, 1, "R10");
    apply(1, 2'b00, 0, splat(2'b00, 64'h80), splat(2'b00, 64'h01), 0, "R4");
    // R9: a non-saturating op keeps the flag
    apply(1, 2'b00, 0, splat(2'b00, 64'h01), splat(2'b00, 64'h01), 0, "R9");
    // R10: clear wins when nothing saturates
    apply(0, 2'b00, 0, '0, '0, 1, "R10");
    // R5: signed clamps, positive and negative
    apply(1, 2'b00, 1, splat(2'b00, 64'h40), splat(2'b00, 64'h01), 0, "R5");
    apply(1, 2'b01, 1, splat(2'b01, 64'hC000), splat(2'b01, 64'h0002), 1, "R5");
    // R10: clear together with a saturating op keeps the flag set
    apply(1, 2'b10, 1, splat(2'b10, 64'h1), splat(2'b10, 64'd40), 1, "R10");
    apply(0, 2'b00, 0, '0, '0, 1, "R10");

    // R6: huge left counts on 64-bit lanes
    apply(1, 2'b11, 0, {64'h1, 64'h1}, {64'd127, 64'd64}, 0, "R6");
    apply(1, 2'b11, 1, {64'hFFFF_FFFF_FFFF_FFFF, 64'h1}, {64'd127, 64'd63}, 1, "R6");
    apply(1, 2'b11, 1, {64'h0, 64'h0}, {64'd127, 64'd100}, 1, "R6");

    // R7: right shifts by -128, -65, exactly -64 and -8
    apply(1, 2'b11, 1, {64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF}, {64'h80, 64'hBF}, 0, "R7");
    apply(1, 2'b11, 0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000}, {64'hBF, 64'hC0}, 0, "R7");
    apply(1, 2'b11, 1, {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF}, {64'hC0, 64'hC0}, 0, "R7");
    apply(1, 2'b00, 0, splat(2'b00, 64'h80), splat(2'b00, 64'hF8), 0, "R7");
    apply(1, 2'b00, 1, splat(2'b00, 64'h80), splat(2'b00, 64'hF8), 0, "R7");

    // R11: idle cycles with changing inputs must hold the result
    apply(0, 2'b10, 1, rnd128(), rnd128(), 0, "R11");
    apply(0, 2'b01, 0, rnd128(), rnd128(), 0, "R11");

    // R8: every size with mixed per-lane counts, both modes
    for (int n = 0; n < 400; n++) begin
      logic [1:0] sz;
      sz = 2'($urandom_range(0, 3));
      apply($urandom_range(0, 3) != 0, sz, 1'($urandom), rnd128(),
            (n % 5 == 0) ? rnd128() : small_counts(sz, rnd128()),
            $urandom_range(0, 7) == 0, "R8");
    end

    apply(0, 2'b00, 0, '0, '0, 0, "R11");
    @(negedge clk);
    check_now();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule